// File: doc/BRIEF.md
# Bus-to-FIFO Access Width Adapter

This block sits between a 32-bit register bus and a pair of byte-wide character queues: one that feeds a transmitter and one that drains a receiver. A bus write is split into a run of pushes into the transmit queue. A bus read is assembled from a run of pops from the receive queue. Each access moves one, two or four bytes.

The byte count comes from a 2-bit size mode held in a small configuration register, together with a byte-select input that is sampled with each access. The lowest byte lane is always handled first. While a multi-byte access is in progress the bus is stalled, and only one access is active at any time.

Top module: `fifo_width_adapter`

## Requirements
- R1: After reset the size mode is 00 (legacy), `bus_stall`, `bus_rvalid`, `tx_push` and `rx_pop` are low, and `bus_rdata` is zero.
- R2: In size mode 00, an access moves 1 byte when `bus_byte_sel` is 1 and 2 bytes when it is 0.
- R3: In size mode 01, every access moves exactly 1 byte, and `bus_byte_sel` has no effect.
- R4: In size mode 10, every access moves exactly 2 bytes, and `bus_byte_sel` has no effect.
- R5: In size mode 11, every access moves 4 bytes, and `bus_byte_sel` has no effect.
- R6: A write pushes the bytes of `bus_wdata` in order: bits 7:0 first, then each higher byte. At most one push happens per clock.
- R7: `tx_push` is never high while `tx_full` is high. Each cycle that the transmit queue is full adds one cycle to the write.
- R8: A read places the k-th popped byte in bits 8k+7:8k of `bus_rdata`. Byte lanes beyond the requested count read as zero.
- R9: If the receive queue runs empty during a read, the lanes still owed read as zero and no pop is issued while `rx_empty` is high.
- R10: `bus_stall` rises on the clock edge that accepts a strobe and stays high until the last byte step is done. Strobes seen while `bus_stall` is high are ignored.
- R11: A read ends with `bus_rvalid` high for exactly one cycle. `bus_rdata` changes only on that cycle and then holds its value.
- R12: While the adapter is idle, a pulse on `cfg_we` loads `cfg_size` into the size mode. The new mode applies to the next access that is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Load strobe for the size mode |
| cfg_size | input | 2 | New size mode: 00 legacy, 01 one byte, 10 two bytes, 11 four bytes |
| bus_wr | input | 1 | Write strobe, accepted while `bus_stall` is low |
| bus_rd | input | 1 | Read strobe, accepted while `bus_stall` is low and `bus_wr` is low |
| bus_byte_sel | input | 1 | Byte-select input, used only in legacy mode |
| bus_wdata | input | 32 | Write word |
| bus_stall | output | 1 | High while an access is in progress |
| bus_rdata | output | 32 | Packed read word |
| bus_rvalid | output | 1 | One-cycle pulse when a read finishes |
| tx_push | output | 1 | Push into the transmit queue |
| tx_data | output | 8 | Byte being pushed |
| tx_full | input | 1 | Transmit queue is full |
| rx_pop | output | 1 | Pop from the receive queue |
| rx_data | input | 8 | Head byte of the receive queue (show-ahead) |
| rx_empty | input | 1 | Receive queue is empty |

## Verification
Call the clock edge that accepts a strobe E0. An access of n bytes with no full cycles performs its byte steps on edges E1 to En, so `bus_stall` is seen high on exactly n falling edges. Each cycle with `tx_full` high adds one more. A read's word and its `bus_rvalid` pulse appear on edge En, so the bench samples them on the first falling edge where the stall has dropped. All inputs are driven on falling edges and all outputs are read there. Pushed bytes and pops are logged on rising edges by the bench's own queue models, and these logs are compared against counts and byte packings computed from the mode, the byte-select and the queue fill.

// File: rtl/fwa_pkg.sv
package fwa_pkg;

    typedef enum logic [1:0] {
        SZ_LEGACY = 2'b00,
        SZ_ONE    = 2'b01,
        SZ_TWO    = 2'b10,
        SZ_FOUR   = 2'b11
    } size_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_WRITE = 2'b01,
        ST_READ  = 2'b10
    } step_state_e;

endpackage

// File: rtl/fwa_count_dec.sv
module fwa_count_dec #(
    parameter int LANES = 4,
    localparam int CW   = $clog2(LANES + 1)
) (
    input  fwa_pkg::size_mode_e mode,
    input  logic                byte_sel,
    output logic [CW-1:0]       n_bytes
);
    localparam int FOUR = (LANES >= 4) ? 4 : LANES;
    localparam int TWO  = (LANES >= 2) ? 2 : LANES;

    always_comb begin
        unique case (mode)
            fwa_pkg::SZ_LEGACY: n_bytes = byte_sel ? CW'(1) : CW'(TWO);
            fwa_pkg::SZ_ONE:    n_bytes = CW'(1);
            fwa_pkg::SZ_TWO:    n_bytes = CW'(TWO);
            default:            n_bytes = CW'(FOUR);
        endcase
    end
endmodule

// File: rtl/fwa_lane_sel.sv
module fwa_lane_sel #(
    parameter int BYTE_W = 8,
    parameter int LANES  = 4,
    localparam int DW    = BYTE_W * LANES,
    localparam int IW    = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [DW-1:0]     word,
    input  logic [IW-1:0]     idx,
    output logic [BYTE_W-1:0] lane
);
    logic [BYTE_W-1:0] lanes_w [LANES];

    for (genvar i = 0; i < LANES; i++) begin : g_split
        assign lanes_w[i] = word[i*BYTE_W +: BYTE_W];
    end

    always_comb begin
        lane = '0;
        for (int i = 0; i < LANES; i++) begin
            if (IW'(i) == idx) lane = lanes_w[i];
        end
    end
endmodule

// File: rtl/fwa_pack.sv
module fwa_pack #(
    parameter int BYTE_W = 8,
    parameter int LANES  = 4,
    localparam int DW    = BYTE_W * LANES,
    localparam int IW    = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [DW-1:0]     word_in,
    input  logic [IW-1:0]     idx,
    input  logic              we,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [DW-1:0]     word_out
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign word_out[i*BYTE_W +: BYTE_W] =
            (we && idx == IW'(i)) ? byte_in : word_in[i*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/fifo_width_adapter.sv
module fifo_width_adapter #(
    parameter int BYTE_W = 8,
    parameter int LANES  = 4,
    localparam int DW    = BYTE_W * LANES,
    localparam int IW    = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int CW    = $clog2(LANES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_size,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              bus_byte_sel,
    input  logic [DW-1:0]     bus_wdata,
    output logic              bus_stall,
    output logic [DW-1:0]     bus_rdata,
    output logic              bus_rvalid,
    output logic              tx_push,
    output logic [BYTE_W-1:0] tx_data,
    input  logic              tx_full,
    output logic              rx_pop,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_empty
);
    import fwa_pkg::*;

    typedef struct packed {
        step_state_e state;
        size_mode_e  mode;
        logic [IW-1:0] idx;
        logic [CW-1:0] total;
        logic [DW-1:0] wbuf;
        logic [DW-1:0] rbuf;
        logic [DW-1:0] rdata;
        logic          rvalid;
    } seq_t;

    seq_t cur_q, nxt_d;

    logic [CW-1:0] n_bytes_d;
    logic [DW-1:0] rbuf_next_d;
    logic          lane_we_d;
    logic          last_step_d;

    fwa_count_dec #(.LANES(LANES)) u_count (
        .mode     (cur_q.mode),
        .byte_sel (bus_byte_sel),
        .n_bytes  (n_bytes_d)
    );

    fwa_lane_sel #(.BYTE_W(BYTE_W), .LANES(LANES)) u_sel (
        .word (cur_q.wbuf),
        .idx  (cur_q.idx),
        .lane (tx_data)
    );

    fwa_pack #(.BYTE_W(BYTE_W), .LANES(LANES)) u_pack (
        .word_in  (cur_q.rbuf),
        .idx      (cur_q.idx),
        .we       (lane_we_d),
        .byte_in  (rx_data),
        .word_out (rbuf_next_d)
    );

    assign last_step_d = (CW'(cur_q.idx) + CW'(1)) == cur_q.total;

    always_comb begin
        nxt_d        = cur_q;
        nxt_d.rvalid = 1'b0;
        tx_push      = 1'b0;
        rx_pop       = 1'b0;
        lane_we_d    = 1'b0;
        unique case (cur_q.state)
            ST_IDLE: begin
                if (cfg_we) nxt_d.mode = size_mode_e'(cfg_size);
                if (bus_wr) begin
                    nxt_d.state = ST_WRITE;
                    nxt_d.idx   = '0;
                    nxt_d.total = n_bytes_d;
                    nxt_d.wbuf  = bus_wdata;
                end else if (bus_rd) begin
                    nxt_d.state = ST_READ;
                    nxt_d.idx   = '0;
                    nxt_d.total = n_bytes_d;
                    nxt_d.rbuf  = '0;
                end
            end
            ST_WRITE: begin
                if (!tx_full) begin
                    tx_push = 1'b1;
                    if (last_step_d) nxt_d.state = ST_IDLE;
                    else             nxt_d.idx   = cur_q.idx + IW'(1);
                end
            end
            ST_READ: begin
                if (!rx_empty) begin
                    rx_pop    = 1'b1;
                    lane_we_d = 1'b1;
                end
                nxt_d.rbuf = rbuf_next_d;
                if (last_step_d) begin
                    nxt_d.state  = ST_IDLE;
                    nxt_d.rdata  = rbuf_next_d;
                    nxt_d.rvalid = 1'b1;
                end else begin
                    nxt_d.idx = cur_q.idx + IW'(1);
                end
            end
            default: nxt_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{state: ST_IDLE, mode: SZ_LEGACY, idx: '0, total: '0,
                       wbuf: '0, rbuf: '0, rdata: '0, rvalid: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign bus_stall  = (cur_q.state != ST_IDLE);
    assign bus_rdata  = cur_q.rdata;
    assign bus_rvalid = cur_q.rvalid;

    // R7: transmit queue is never written while it reports full
    a_r7_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        tx_push |-> !tx_full);

    // R9: nothing is taken from an empty receive queue
    a_r9_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |-> !rx_empty);

    // R10: an accepted strobe stalls the bus in the next cycle
    a_r10_stall_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_stall && (bus_wr || bus_rd)) |=> bus_stall);

    // R11: the completion pulse lasts a single cycle and leaves the bus free
    a_r11_rvalid_single: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |=> !bus_rvalid);

    a_r11_rvalid_idle: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> !bus_stall);

    // R11: the read word moves only together with the completion pulse
    a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rvalid |-> $stable(bus_rdata));

    // R6: a push and a pop never share one cycle
    a_r6_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_push && rx_pop));
endmodule

// File: tb/fifo_width_adapter_bench.sv
module fifo_width_adapter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_size = 2'b00;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_byte_sel = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_stall;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        tx_push;
    logic [7:0]  tx_data;
    logic        tx_full = 1'b0;
    logic        rx_pop;
    logic [7:0]  rx_data;
    logic        rx_empty;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    fifo_width_adapter u_fifo_width_adapter (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_size(cfg_size),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_byte_sel(bus_byte_sel),
        .bus_wdata(bus_wdata), .bus_stall(bus_stall), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .tx_push(tx_push), .tx_data(tx_data),
        .tx_full(tx_full), .rx_pop(rx_pop), .rx_data(rx_data), .rx_empty(rx_empty)
    );

    // transmit queue log and receive queue model
    logic [7:0] txlog [64];
    int         tx_n = 0;
    logic [7:0] rxq [64];
    int         rx_head = 0;
    int         rx_tail = 0;

    always @(posedge clk) begin
        if (tx_push) begin
            txlog[tx_n % 64] <= tx_data;
            tx_n <= tx_n + 1;
        end
        if (rx_pop) rx_head <= rx_head + 1;
    end

    always_comb begin
        rx_empty = (rx_tail == rx_head);
        rx_data  = rxq[rx_head % 64];
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_count(input int mode, input bit bsel);
        case (mode)
            0: return bsel ? 1 : 2;
            1: return 1;
            2: return 2;
            default: return 4;
        endcase
    endfunction

    task automatic set_mode(input int m);
        @(negedge clk);
        cfg_size = 2'(m);
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_write(input string req, input int n, input logic [31:0] w,
                            input bit bsel, input int full_cyc, input bit inject);
        int base;
        int cyc;
        bit ok;
        @(negedge clk);
        base = tx_n;
        bus_wdata = w;
        bus_byte_sel = bsel;
        bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        cyc = 0;
        while (bus_stall && cyc < 100) begin
            tx_full = (cyc < full_cyc);
            bus_wr = inject && (cyc == 1);
            bus_wdata = inject ? 32'hDEADBEEF : w;
            cyc++;
            @(negedge clk);
        end
        tx_full = 1'b0;
        bus_wr = 1'b0;
        check(cyc == n + full_cyc, {req, " stall cycles"}, cyc, n + full_cyc);
        check(tx_n - base == n, {req, " push count"}, tx_n - base, n);
        ok = 1'b1;
        for (int i = 0; i < n; i++)
            if (txlog[(base + i) % 64] != w[i*8 +: 8]) ok = 1'b0;
        check(ok, {req, " R6 byte order"}, txlog[base % 64], w[7:0]);
        if (inject) begin
            @(negedge clk);
            @(negedge clk);
            check(!bus_stall && tx_n - base == n, "R10 stalled strobe ignored", tx_n - base, n);
        end
    endtask

    task automatic do_read(input string req, input int n, input bit bsel, input int k);
        int avail;
        int base;
        int cyc;
        int got;
        logic [31:0] exp;
        @(negedge clk);
        for (int i = 0; i < k; i++) rxq[(rx_tail + i) % 64] = 8'(8'h40 + rx_tail + i);
        rx_tail = rx_tail + k;
        avail = rx_tail - rx_head;
        base = rx_head;
        got = (avail < n) ? avail : n;
        exp = '0;
        for (int i = 0; i < got; i++) exp[i*8 +: 8] = rxq[(base + i) % 64];
        bus_byte_sel = bsel;
        bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        cyc = 0;
        while (bus_stall && cyc < 100) begin
            cyc++;
            @(negedge clk);
        end
        check(cyc == n, {req, " read stall cycles"}, cyc, n);
        check(bus_rvalid == 1'b1, "R11 rvalid at completion", bus_rvalid, 1);
        check(bus_rdata == exp, {req, " R8 R9 packed word"}, bus_rdata, exp);
        check(rx_head - base == got, {req, " R9 pop count"}, rx_head - base, got);
        @(negedge clk);
        check(bus_rvalid == 1'b0 && bus_rdata == exp, "R11 pulse ends, word holds", bus_rdata, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        string tag;
        int s;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!bus_stall && !bus_rvalid && !tx_push && !rx_pop, "R1 idle outputs", bus_stall, 0);
        check(bus_rdata == 32'h0, "R1 rdata zero", bus_rdata, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: default legacy mode before any configuration write
        do_write("R1 default legacy bsel=0", 2, 32'h11223344, 1'b0, 0, 1'b0);
        do_write("R1 default legacy bsel=1", 1, 32'h55667788, 1'b1, 0, 1'b0);

        for (int m = 0; m < 4; m++) begin
            // R12: mode change applies to the following access
            set_mode(m);
            case (m)
                0: tag = "R2";
                1: tag = "R3";
                2: tag = "R4";
                default: tag = "R5";
            endcase
            for (int b = 0; b < 2; b++) begin
                s = m * 8 + b * 4;
                do_write({tag, " R12 write"}, exp_count(m, b[0]),
                         32'h0A1B2C3D ^ {4{8'(s)}}, b[0], 0, 1'b0);
                for (int kk = 0; kk < 4; kk++) begin
                    int n;
                    int k;
                    n = exp_count(m, b[0]);
                    case (kk)
                        0: k = 0;
                        1: k = (n > 1) ? n - 1 : 0;
                        2: k = n;
                        default: k = n + 1;
                    endcase
                    do_read({tag, " R12 read"}, n, b[0], k);
                end
            end
        end

        // R7: full queue holds off pushes, one cycle per full cycle
        do_write("R7 full hold-off", 4, 32'hCAFEF00D, 1'b0, 3, 1'b0);
        set_mode(1);
        do_write("R7 full hold-off one byte", 1, 32'h000000A5, 1'b0, 2, 1'b0);
        // R10: strobe during stall is dropped
        set_mode(3);
        do_write("R10 four-byte with stray strobe", 4, 32'h89ABCDEF, 1'b1, 0, 1'b1);
        // R9: empty receive queue yields zero word and no pops
        while (rx_tail != rx_head) do_read("R9 drain", 4, 1'b0, 0);
        do_read("R9 empty", 4, 1'b0, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule